// File: doc/BRIEF.md
# Single-Bit NAND ECC Corrector

The block takes the ECC bytes read back from a flash spare area and the ECC bytes just computed over the data, and judges one 256-byte chunk at a time. Each code word is 24 bits wide, built from three bytes with the lowest byte first. The XOR of the two words, together with a check across the two 11-bit parity halves, gives one of four results: clean, a fault in the ECC field itself, a single data bit that can be repaired, or damage that cannot be repaired. For a repairable fault the block reports which byte and which bit the caller must invert. It does not touch the data memory.

The caller presents both code buffers and pulses `start_i` while the block is idle. For a small page only the three bytes at offset 0 are judged. For a large page (`big_page_i` high) a second pass follows at once, using the three bytes at offset 8 of each buffer and covering page bytes 256 to 511. Each pass ends with a one-cycle `done_o` pulse. The second pulse carries `last_o`, and its status is the status for the whole page.

Top module: `ecc1_corrector`

## Requirements
- R1: Code words are packed little-endian: buffer byte k sits in bits [8k+7:8k]. Pass 0 takes bytes 0,1,2 as code bits [7:0],[15:8],[23:16]. Pass 1 takes bytes 8,9,10. Bytes 3 to 7 are never used.
- R2: A syndrome (computed XOR stored) of zero gives status 0 (clean).
- R3: If either code word is zero, the status is 0 (clean) whatever the syndrome.
- R4: A syndrome with exactly one bit set gives status 1 (ECC field fault), and the byte and bit outputs are zero.
- R5: A syndrome with exactly eleven bits set, where the XOR of its low 11 bits and bits [21:11] is all ones, gives status 2 (repairable). `err_bit_o` is set from syndrome bits [2:0], and `err_byte_o` is the pass index times 256 plus syndrome bits [10:3].
- R6: Any other syndrome gives status 3 (unrepairable), with zero location outputs. This includes eleven set bits that fail the half check.
- R7: A start accepted while idle makes `done_o` high for exactly one cycle, on the clock edge after the start is sampled. For a small page `last_o` is high and `chunk_o` is 0 on that pulse.
- R8: For a large page, `done_o` is high on two consecutive cycles. The first pulse has `chunk_o`=0 and `last_o`=0. The second has `chunk_o`=1 and `last_o`=1 and gives the final page status.
- R9: `start_i` and the buffer inputs are ignored while `busy_o` is high. The passes already underway report results from the buffers captured at the accepted start.
- R10: After reset, `done_o`, `busy_o`, `last_o` and `status_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a compare; taken only when idle |
| big_page_i | input | 1 | High for a 512-byte page (two passes) |
| calc_buf_i | input | 88 | Computed ECC bytes, byte k in bits [8k+7:8k] |
| stor_buf_i | input | 88 | Stored ECC bytes, same layout |
| busy_o | output | 1 | Passes are in progress |
| done_o | output | 1 | One-cycle pulse per finished pass |
| last_o | output | 1 | Marks the final pass of the page |
| chunk_o | output | 1 | Index of the pass being reported |
| status_o | output | 2 | 0 clean, 1 ECC field fault, 2 repairable, 3 unrepairable |
| err_byte_o | output | 9 | Page byte offset to invert when status is 2 |
| err_bit_o | output | 3 | Bit within that byte when status is 2 |

## Verification
The assertions take for granted that nothing reloads the captured buffers during a pass. Their pulse-pairing checks rely on a large-page request always running both passes back to back, with no stall between them. The stimulus holds start for a single cycle when idle. In one scenario it deliberately holds start high, with different buffers, during a pass, so that the ignore rule is exercised against the captured copy. Repairable syndromes are built in the bench as a location in the low half and its complement in the high half, which keeps them inside the pattern a true single data-bit flip produces.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int CODE_BYTES = 3;
  localparam int CODE_W     = 8 * CODE_BYTES;
  localparam int HALF_W     = 11;
  localparam int POP_W      = $clog2(CODE_W + 1);

  typedef enum logic [1:0] {
    ECC_CLEAN     = 2'd0,
    ECC_FIELD_ERR = 2'd1,
    ECC_FIXED     = 2'd2,
    ECC_BAD       = 2'd3
  } ecc_status_e;

  // little-endian assembly of one code word
  function automatic logic [CODE_W-1:0] pack_code(input logic [7:0] b0,
                                                  input logic [7:0] b1,
                                                  input logic [7:0] b2);
    return {b2, b1, b0};
  endfunction

  function automatic logic [POP_W-1:0] pop_count(input logic [CODE_W-1:0] v);
    logic [POP_W-1:0] n;
    n = '0;
    for (int i = 0; i < CODE_W; i++) n = n + POP_W'(v[i]);
    return n;
  endfunction

  // low half XOR high half of a code word
  function automatic logic [HALF_W-1:0] fold_halves(input logic [CODE_W-1:0] v);
    return v[HALF_W-1:0] ^ v[2*HALF_W-1:HALF_W];
  endfunction
endpackage

// File: rtl/ecc_pass_sel.sv
module ecc_pass_sel
  import nand_ecc_pkg::*;
#(
  parameter int MAX_PASSES  = 2,
  parameter int CODE_STRIDE = 8,
  localparam int BUF_BYTES  = CODE_STRIDE * (MAX_PASSES - 1) + CODE_BYTES,
  localparam int PASS_W     = (MAX_PASSES > 1) ? $clog2(MAX_PASSES) : 1
) (
  input  logic [8*BUF_BYTES-1:0] buf_i,
  input  logic [PASS_W-1:0]      pass_i,
  output logic [CODE_W-1:0]      code_o
);
  logic [CODE_W-1:0] codes [MAX_PASSES];

  for (genvar p = 0; p < MAX_PASSES; p++) begin : g_pass
    localparam int BASE = p * CODE_STRIDE;
    assign codes[p] = pack_code(buf_i[8*BASE +: 8],
                                buf_i[8*(BASE+1) +: 8],
                                buf_i[8*(BASE+2) +: 8]);
  end

  always_comb begin
    code_o = codes[0];
    for (int p = 0; p < MAX_PASSES; p++)
      if (pass_i == PASS_W'(p)) code_o = codes[p];
  end
endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import nand_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] calc_i,
  input  logic [CODE_W-1:0] stor_i,
  output logic [CODE_W-1:0] syn_o,
  output logic [HALF_W-1:0] loc_o,
  output logic [HALF_W-1:0] cross_o,
  output logic              zero_code_o
);
  logic [HALF_W-1:0] calc_fold, stor_fold;

  assign syn_o       = calc_i ^ stor_i;
  assign loc_o       = calc_i[HALF_W-1:0] ^ stor_i[HALF_W-1:0];
  assign calc_fold   = fold_halves(calc_i);
  assign stor_fold   = fold_halves(stor_i);
  assign cross_o     = calc_fold ^ stor_fold;
  assign zero_code_o = (calc_i == '0) || (stor_i == '0);
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import nand_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] syn_i,
  input  logic [HALF_W-1:0] cross_i,
  input  logic              zero_code_i,
  output logic [POP_W-1:0]  pop_o,
  output ecc_status_e       status_o
);
  localparam logic [POP_W-1:0]  FIX_POP   = POP_W'(HALF_W);
  localparam logic [HALF_W-1:0] ALL_CROSS = '1;

  assign pop_o = pop_count(syn_i);

  always_comb begin
    if (zero_code_i || syn_i == '0)                   status_o = ECC_CLEAN;
    else if (pop_o == POP_W'(1))                      status_o = ECC_FIELD_ERR;
    else if (pop_o == FIX_POP && cross_i == ALL_CROSS) status_o = ECC_FIXED;
    else                                              status_o = ECC_BAD;
  end
endmodule

// File: rtl/ecc1_corrector.sv
module ecc1_corrector
  import nand_ecc_pkg::*;
#(
  parameter int MAX_PASSES  = 2,
  parameter int CODE_STRIDE = 8,
  parameter int CHUNK_BITS  = 8,
  localparam int BUF_BYTES  = CODE_STRIDE * (MAX_PASSES - 1) + CODE_BYTES,
  localparam int PASS_W     = (MAX_PASSES > 1) ? $clog2(MAX_PASSES) : 1,
  localparam int OFS_W      = CHUNK_BITS + PASS_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   big_page_i,
  input  logic [8*BUF_BYTES-1:0] calc_buf_i,
  input  logic [8*BUF_BYTES-1:0] stor_buf_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   last_o,
  output logic [PASS_W-1:0]      chunk_o,
  output logic [1:0]             status_o,
  output logic [OFS_W-1:0]       err_byte_o,
  output logic [2:0]             err_bit_o
);
  typedef enum logic {ST_IDLE, ST_EVAL} state_e;

  state_e                 st_q;
  logic                   big_q;
  logic [PASS_W-1:0]      pass_q;
  logic [8*BUF_BYTES-1:0] calc_q, stor_q;
  logic                   done_q, last_q;
  logic [PASS_W-1:0]      chunk_q;
  ecc_status_e            status_q;
  logic [OFS_W-1:0]       byte_q;
  logic [2:0]             bit_q;
  logic [POP_W-1:0]       pop_q;

  // named internal events
  logic                   accept_w;
  logic                   final_pass_w;
  logic [CODE_W-1:0]      calc_code_w, stor_code_w, syn_w;
  logic [HALF_W-1:0]      loc_w, cross_w;
  logic                   zero_w;
  logic [POP_W-1:0]       pop_w;
  ecc_status_e            class_w;

  assign accept_w     = (st_q == ST_IDLE) && start_i;
  assign final_pass_w = !big_q || (pass_q == PASS_W'(MAX_PASSES - 1));

  ecc_pass_sel #(.MAX_PASSES(MAX_PASSES), .CODE_STRIDE(CODE_STRIDE)) u_sel_calc (
    .buf_i(calc_q), .pass_i(pass_q), .code_o(calc_code_w));
  ecc_pass_sel #(.MAX_PASSES(MAX_PASSES), .CODE_STRIDE(CODE_STRIDE)) u_sel_stor (
    .buf_i(stor_q), .pass_i(pass_q), .code_o(stor_code_w));

  ecc_syndrome u_syn (
    .calc_i(calc_code_w), .stor_i(stor_code_w), .syn_o(syn_w),
    .loc_o(loc_w), .cross_o(cross_w), .zero_code_o(zero_w));

  ecc_classify u_cls (
    .syn_i(syn_w), .cross_i(cross_w), .zero_code_i(zero_w),
    .pop_o(pop_w), .status_o(class_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      big_q    <= 1'b0;
      pass_q   <= '0;
      calc_q   <= '0;
      stor_q   <= '0;
      done_q   <= 1'b0;
      last_q   <= 1'b0;
      chunk_q  <= '0;
      status_q <= ECC_CLEAN;
      byte_q   <= '0;
      bit_q    <= '0;
      pop_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        st_q   <= ST_EVAL;
        big_q  <= big_page_i;
        pass_q <= '0;
        calc_q <= calc_buf_i;
        stor_q <= stor_buf_i;
      end else if (st_q == ST_EVAL) begin
        done_q   <= 1'b1;
        last_q   <= final_pass_w;
        chunk_q  <= pass_q;
        status_q <= class_w;
        pop_q    <= pop_w;
        if (class_w == ECC_FIXED) begin
          byte_q <= {pass_q, loc_w[HALF_W-1:3]};
          bit_q  <= loc_w[2:0];
        end else begin
          byte_q <= '0;
          bit_q  <= '0;
        end
        if (final_pass_w) st_q <= ST_IDLE;
        else              pass_q <= pass_q + PASS_W'(1);
      end
    end
  end

  assign busy_o     = (st_q == ST_EVAL);
  assign done_o     = done_q;
  assign last_o     = last_q;
  assign chunk_o    = chunk_q;
  assign status_o   = status_q;
  assign err_byte_o = byte_q;
  assign err_bit_o  = bit_q;

  // R9
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVAL) |=> ($stable(calc_q) && $stable(stor_q)));

  // R5
  fix_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && status_q == ECC_FIXED) |-> (pop_q == POP_W'(HALF_W)));

  // R6
  loc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && status_q != ECC_FIXED) |-> (byte_q == '0 && bit_q == '0));

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(st_q == ST_EVAL));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && last_q) |=> !done_q);

  // R8
  pass_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !last_q) |=> (done_q && chunk_q != $past(chunk_q)));
endmodule

// File: tb/sim_ecc1_corrector.sv
module sim_ecc1_corrector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        big_page_i = 1'b0;
  logic [87:0] calc_buf_i = '0;
  logic [87:0] stor_buf_i = '0;
  logic        busy_o, done_o, last_o;
  logic [0:0]  chunk_o;
  logic [1:0]  status_o;
  logic [8:0]  err_byte_o;
  logic [2:0]  err_bit_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ecc1_corrector u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .big_page_i(big_page_i),
    .calc_buf_i(calc_buf_i), .stor_buf_i(stor_buf_i), .busy_o(busy_o),
    .done_o(done_o), .last_o(last_o), .chunk_o(chunk_o), .status_o(status_o),
    .err_byte_o(err_byte_o), .err_bit_o(err_bit_o));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // repairable syndrome for page-bit location l (11 bits)
  function automatic logic [23:0] fix_syn(input logic [10:0] l);
    return {2'b00, ~l, l};
  endfunction

  // fill buffers: junk in bytes 3..7, codes at offsets 0 and 8 (lsb first)
  function automatic logic [87:0] mk_buf(input logic [23:0] c0, input logic [23:0] c1);
    logic [87:0] b;
    b = {88{1'b1}};
    for (int i = 0; i < 3; i++) begin
      b[8*i +: 8]     = c0[8*i +: 8];
      b[8*(8+i) +: 8] = c1[8*i +: 8];
    end
    return b;
  endfunction

  task automatic launch(input logic big, input logic [23:0] c0, input logic [23:0] s0,
                        input logic [23:0] c1, input logic [23:0] s1);
    @(negedge clk);
    big_page_i = big;
    calc_buf_i = mk_buf(c0, c1);
    stor_buf_i = mk_buf(s0, s1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    calc_buf_i = '0;
    stor_buf_i = '0;
  endtask

  task automatic expect_pass(input string req, input logic last, input logic chunk,
                             input logic [1:0] st, input logic [8:0] by, input logic [2:0] bi);
    @(negedge clk);
    chk(req, "done", done_o, 1'b1);
    chk(req, "last", last_o, last);
    chk(req, "chunk", chunk_o, chunk);
    chk(req, "status", status_o, st);
    chk(req, "byte", err_byte_o, by);
    chk(req, "bit", err_bit_o, bi);
  endtask

  task automatic expect_quiet(input string req);
    @(negedge clk);
    chk(req, "done low after pulse", done_o, 1'b0);
  endtask

  localparam logic [23:0] BASE = 24'h5A3C69;

  task automatic t_reset;
    chk("R10", "done", done_o, 0);
    chk("R10", "busy", busy_o, 0);
    chk("R10", "last", last_o, 0);
    chk("R10", "status", status_o, 0);
  endtask

  task automatic t_clean;
    launch(1'b0, BASE, BASE, 24'h0, 24'h0);
    expect_pass("R2", 1'b1, 1'b0, 2'd0, 9'd0, 3'd0);
    expect_quiet("R7");
  endtask

  task automatic t_zero_code;
    launch(1'b0, 24'h123456, 24'h0, 24'h0, 24'h0);
    expect_pass("R3", 1'b1, 1'b0, 2'd0, 9'd0, 3'd0);
    launch(1'b0, 24'h0, BASE, 24'h0, 24'h0);
    expect_pass("R3", 1'b1, 1'b0, 2'd0, 9'd0, 3'd0);
  endtask

  task automatic t_field;
    launch(1'b0, BASE ^ 24'h020000, BASE, 24'h0, 24'h0);
    expect_pass("R4", 1'b1, 1'b0, 2'd1, 9'd0, 3'd0);
  endtask

  task automatic t_fix_small;
    // location 0x4D3: byte 0x9A, bit 3
    launch(1'b0, BASE ^ fix_syn(11'h4D3), BASE, 24'h0, 24'h0);
    expect_pass("R5", 1'b1, 1'b0, 2'd2, 9'h09A, 3'd3);
  endtask

  task automatic t_bad;
    launch(1'b0, BASE ^ 24'h000300, BASE, 24'h0, 24'h0);
    expect_pass("R6", 1'b1, 1'b0, 2'd3, 9'd0, 3'd0);
    // eleven bits set but halves fail the complement check
    launch(1'b0, BASE ^ 24'hC001FF, BASE, 24'h0, 24'h0);
    expect_pass("R6", 1'b1, 1'b0, 2'd3, 9'd0, 3'd0);
  endtask

  task automatic t_big;
    // pass 0: byte 2 bit 5; pass 1: last byte of chunk, bit 7 -> page byte 511
    launch(1'b1, BASE ^ fix_syn(11'h015), BASE, 24'h3C0F11 ^ fix_syn(11'h7FF), 24'h3C0F11);
    expect_pass("R8", 1'b0, 1'b0, 2'd2, 9'd2, 3'd5);
    expect_pass("R1", 1'b1, 1'b1, 2'd2, 9'd511, 3'd7);
    expect_quiet("R8");
    // final status from second pass
    launch(1'b1, BASE ^ fix_syn(11'h001), BASE, 24'h777777 ^ 24'h000003, 24'h777777);
    expect_pass("R8", 1'b0, 1'b0, 2'd2, 9'd0, 3'd1);
    expect_pass("R8", 1'b1, 1'b1, 2'd3, 9'd0, 3'd0);
  endtask

  task automatic t_ignore_busy;
    @(negedge clk);
    big_page_i = 1'b1;
    calc_buf_i = mk_buf(BASE, BASE ^ fix_syn(11'h123));
    stor_buf_i = mk_buf(BASE, BASE);
    start_i = 1'b1;
    @(negedge clk);
    chk("R9", "busy", busy_o, 1'b1);
    big_page_i = 1'b0;
    calc_buf_i = mk_buf(BASE ^ 24'h000001, 24'h0);
    stor_buf_i = mk_buf(BASE, 24'h0);
    @(negedge clk);
    start_i = 1'b0;
    chk("R9", "done", done_o, 1'b1);
    chk("R9", "status", status_o, 2'd0);
    chk("R9", "last", last_o, 1'b0);
    @(negedge clk);
    chk("R9", "done", done_o, 1'b1);
    chk("R9", "status", status_o, 2'd2);
    chk("R9", "byte", err_byte_o, 9'h124);
    chk("R9", "bit", err_bit_o, 3'd3);
    expect_quiet("R9");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_zero_code();
        t_field();
        t_fix_small();
        t_bad();
        t_big();
        t_ignore_busy();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule